// File: doc/BRIEF.md
# Data Cache Clean-and-Empty Sequencer

This block walks a data cache so that the cache can be emptied without losing modified data. It does not need to know which lines are dirty. In flush mode it makes two passes over the whole cache, one block at a time:

- The first pass loads known memory into every line, which forces any modified lines out.
- The second pass sends a flush-and-invalidate command for each of those same blocks.

When the cache contents may be thrown away, a single flash-invalidate command empties the cache instead. There are two ways to get that command. One is a start request in discard mode. The other is writing a control bit to one and then back to zero.

The cache array and the memory behind it are not part of the block. It talks to them through one command port. A command stays on that port until the cache raises ready. A busy flag and a one-cycle done pulse report progress.

Top module: `dcache_sweep_seq`

## Requirements
- R1: After reset `busy`, `done` and `cmd_valid` are low, and `cmd_valid` stays low whenever the sequencer is idle.
- R2: A start with `discard` low issues CACHE_BYTES/BLOCK_BYTES load commands (`cmd_op` = 2'b01). The first goes to the base address and each later one is BLOCK_BYTES higher. All of them are accepted before any other command.
- R3: After the last load is accepted, the same number of flush-and-invalidate commands (`cmd_op` = 2'b10) follow. They start again at the base address and step by BLOCK_BYTES.
- R4: The low log2(BLOCK_BYTES) bits of `base_addr` are ignored, and every issued address has those bits at zero.
- R5: A start with `discard` high issues exactly one flash-invalidate command (`cmd_op` = 2'b11) and no load or flush command.
- R6: A control write with bit 21 at one, followed by a control write with bit 21 at zero, issues exactly one flash-invalidate command. Writing one several times before the zero still gives one. A zero write with no preceding one, or writes that leave bit 21 at zero, issue nothing.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_addr` hold their values into the next cycle.
- R8: `busy` rises in the cycle after an accepted start and falls at the clock edge that accepts the final command. `done` is high for exactly that one following cycle.
- R9: A start request, or a bit-21 set-then-clear, that arrives while busy has no effect on the commands issued or on the number of done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a sequence; sampled only when idle |
| discard | input | 1 | With start: 1 = flash invalidate only, 0 = fill then flush |
| base_addr | input | ADDR_W | Base of the fill/flush walk; low bits ignored |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data; bit 21 is the invalidate trigger |
| cmd_valid | output | 1 | Command present on the cache port |
| cmd_op | output | 2 | 01 load, 10 flush block, 11 flash invalidate |
| cmd_addr | output | ADDR_W | Block address of the command |
| cmd_ready | input | 1 | Cache accepts the command this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
Flush mode runs on an 8-block cache under three ready patterns: always ready, every other cycle, and pseudo-random. Together they separate a walk that advances on acceptance from one that advances on every cycle. Each run records the full command trace and compares it with the arithmetic block sequence. An unaligned base and a base that wraps the address space expose masking and carry faults. The control-bit tests apply lone sets, lone clears, repeated sets and unrelated bits, which tells edge detection apart from level detection. Start and trigger requests made mid-walk show whether requests are gated while busy.

// File: rtl/dcache_sweep_seq.sv
module dcache_sweep_seq #(
  parameter int CACHE_BYTES = 16384,
  parameter int BLOCK_BYTES = 32,
  parameter int ADDR_W      = 32,
  parameter int INV_BIT     = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              discard,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              ctl_wr,
  input  logic [31:0]       ctl_wdata,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_ready,
  output logic              busy,
  output logic              done
);
  localparam int NBLK  = CACHE_BYTES / BLOCK_BYTES;
  localparam int OFS_W = $clog2(BLOCK_BYTES);
  localparam int CNT_W = $clog2(NBLK + 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_FLUSH, S_FLASH} state_t;

  state_t            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q, base_q;
  logic              inv_q;

  wire [ADDR_W-1:0] aligned   = {base_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  wire              accept    = cmd_valid && cmd_ready;
  wire              last      = cnt_q == CNT_W'(1);
  wire              flash_evt = ctl_wr && inv_q && !ctl_wdata[INV_BIT];

  assign busy      = state_q != S_IDLE;
  assign cmd_valid = busy;
  assign cmd_addr  = addr_q;
  assign cmd_op    = (state_q == S_FILL)  ? 2'b01 :
                     (state_q == S_FLUSH) ? 2'b10 :
                     (state_q == S_FLASH) ? 2'b11 : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      inv_q   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl_wr) inv_q <= ctl_wdata[INV_BIT];
      case (state_q)
        S_IDLE: begin
          if (start && discard) begin
            state_q <= S_FLASH;
          end else if (start) begin
            state_q <= S_FILL;
            base_q  <= aligned;
            addr_q  <= aligned;
            cnt_q   <= CNT_W'(NBLK);
          end else if (flash_evt) begin
            state_q <= S_FLASH;
          end
        end
        S_FILL: if (accept) begin
          if (last) begin
            state_q <= S_FLUSH;
            addr_q  <= base_q;
            cnt_q   <= CNT_W'(NBLK);
          end else begin
            addr_q <= addr_q + ADDR_W'(BLOCK_BYTES);
            cnt_q  <= cnt_q - 1'b1;
          end
        end
        S_FLUSH: if (accept) begin
          if (last) begin
            state_q <= S_IDLE;
            done    <= 1'b1;
          end else begin
            addr_q <= addr_q + ADDR_W'(BLOCK_BYTES);
            cnt_q  <= cnt_q - 1'b1;
          end
        end
        default: if (accept) begin
          state_q <= S_IDLE;
          done    <= 1'b1;
        end
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid); // R1
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_addr[OFS_W-1:0] == '0); // R4
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'b11 |=> done && !busy); // R8
endmodule

// File: tb/dcache_sweep_seq_test.sv
module dcache_sweep_seq_test;
  localparam int CB = 256, BB = 32, N = CB / BB;

  logic clk = 0, rst_n = 0, start = 0, discard = 0, ctl_wr = 0, cmd_ready = 0;
  logic [31:0] base_addr = 0, ctl_wdata = 0;
  logic cmd_valid, busy, done;
  logic [1:0] cmd_op;
  logic [31:0] cmd_addr;

  dcache_sweep_seq #(.CACHE_BYTES(CB), .BLOCK_BYTES(BB), .ADDR_W(32), .INV_BIT(21)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .discard(discard), .base_addr(base_addr),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .busy(busy), .done(done));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int rmode = 0, lcnt = 0, done_cnt = 0, hold_err = 0;
  logic [1:0] lop [0:63];
  logic [31:0] laddr [0:63];
  logic [7:0] lfsr = 8'hA5;
  logic pend = 0;
  logic [1:0] p_op;
  logic [31:0] p_addr;

  always @(negedge clk) begin
    if (pend && (!cmd_valid || cmd_op != p_op || cmd_addr != p_addr)) hold_err++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rmode)
      0: cmd_ready = 1'b1;
      1: cmd_ready = ~cmd_ready;
      default: cmd_ready = lfsr[0];
    endcase
    if (cmd_valid && cmd_ready && lcnt < 64) begin
      lop[lcnt] = cmd_op;
      laddr[lcnt] = cmd_addr;
      lcnt++;
    end
    pend = cmd_valid && !cmd_ready;
    p_op = cmd_op;
    p_addr = cmd_addr;
    if (done) done_cnt++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    lcnt = 0; done_cnt = 0; hold_err = 0;
  endtask

  task automatic pulse_start(input logic disc, input logic [31:0] base);
    @(negedge clk); start = 1; discard = disc; base_addr = base;
    @(negedge clk); start = 0; discard = 0;
  endtask

  task automatic ctl_write(input logic [31:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0; ctl_wdata = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic flush_run(input logic [31:0] base, input int mode, input bit mid_start);
    logic [31:0] b;
    b = {base[31:5], 5'd0};
    rmode = mode;
    clear_log();
    pulse_start(0, base);
    check(busy === 1'b1, "R8", "busy after start", busy, 1);
    if (mid_start) begin
      pulse_start(1, 32'h4000);
      pulse_start(0, 32'h8000);
      ctl_write(32'h0020_0000);
      ctl_write(32'h0);
    end
    wait_done();
    check(lcnt == 2 * N, "R9", "command count", lcnt, 2 * N);
    for (int i = 0; i < N; i++) begin
      check(lop[i] == 2'b01, "R2", "load op", lop[i], 1);
      check(laddr[i] == b + 32'(i * BB), "R2", "load addr", laddr[i], b + 32'(i * BB));
      check(lop[N + i] == 2'b10, "R3", "flush op", lop[N + i], 2);
      check(laddr[N + i] == b + 32'(i * BB), "R3", "flush addr", laddr[N + i], b + 32'(i * BB));
      check(laddr[i][4:0] == 5'd0, "R4", "aligned", laddr[i][4:0], 0);
    end
    check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    check(busy == 1'b0, "R8", "busy after done", busy, 0);
    check(hold_err == 0, "R7", "hold violations", hold_err, 0);
  endtask

  task automatic expect_flash(input int exp_n, input string req);
    repeat (10) @(negedge clk);
    check(lcnt == exp_n, req, "flash command count", lcnt, exp_n);
    if (exp_n == 1) check(lop[0] == 2'b11, req, "flash op", lop[0], 3);
    check(done_cnt == exp_n, req, "done pulses", done_cnt, exp_n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && cmd_valid == 0, "R1", "reset outputs",
          {busy, done, cmd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(cmd_valid == 0, "R1", "idle valid", cmd_valid, 0);

    flush_run(32'h0, 0, 0);
    flush_run(32'h1000_0013, 1, 0);
    flush_run(32'hFFFF_FF9F, 2, 0);
    flush_run(32'h0000_2000, 2, 1);

    rmode = 2;
    clear_log(); pulse_start(1, 32'h0);
    check(busy === 1'b1, "R8", "busy after discard start", busy, 1);
    expect_flash(1, "R5");

    clear_log(); ctl_write(32'h0020_0000); ctl_write(32'h0);
    expect_flash(1, "R6");
    clear_log(); ctl_write(32'h0);
    expect_flash(0, "R6");
    clear_log(); ctl_write(32'h0020_0000); ctl_write(32'h0020_0000); ctl_write(32'h0);
    expect_flash(1, "R6");
    clear_log(); ctl_write(32'hFFDF_FFFF); ctl_write(32'h0);
    expect_flash(0, "R6");
    check(cmd_valid == 0 && busy == 0, "R1", "idle after all", {cmd_valid, busy}, 0);

    summary();
  end
endmodule